// File: doc/BRIEF.md
# Threshold Offset Register Loader

This block keeps the two threshold offsets that a buffer's almost-empty and almost-full flag logic compares against, and lets a host program and inspect them over the buffer's ordinary data pins. While the shared active-low load strobe is held, each write-enabled edge of the write clock stores the low bits of the input word into one of the two offsets: the empty-side offset first, then the full-side offset, then the empty-side offset again, and so on round-robin.

Read-back works the same way in the read-clock domain: while load is held, each read-enabled edge of the read clock places the next offset on the readback bus, in the same empty-then-full order, driven by a pointer of its own. The write pointer and the readback pointer never influence each other, and a programming run that is cut short by releasing load continues with the following register the next time load is asserted. Both offsets are always visible to the flag logic on dedicated outputs. A load-write and a load-read must not be issued in the same cycle.

Top module: `ofs_load_seq`

## Requirements
- R1: While `rstN` is low, both offsets take the default set by `DEPTH` (31 for a depth of 256 or less, 63 for a depth of 512 or less, 127 otherwise; 127 with the default `DEPTH` of 1024), `rdData` becomes 0, and both the write and the readback pointer point at the empty-side offset.
- R2: On a write-clock edge with `loadN` and `wrEnN` both low, the addressed offset takes `dataIn[11:0]` and the write pointer advances; successive such edges address empty, full, empty, full, and so on.
- R3: Input bits `dataIn[17:12]` are never stored; only bits 11..0 reach an offset.
- R4: With `loadN` low and `wrEnN` high, a write-clock edge changes neither offset nor the write pointer.
- R5: With `loadN` high, no edge changes either offset, either pointer or `rdData`, whatever `wrEnN` and `rdEnN` are.
- R6: Releasing `loadN` in the middle of a sequence keeps the write pointer, so the next load-write addresses the register after the last one written.
- R7: On a read-clock edge with `loadN` and `rdEnN` both low, `rdData` takes the offset addressed by the readback pointer, zero-extended so that bits 17..12 are 0, and that pointer advances empty, full, empty; load-writes never move it, and a load-write and a load-read are never issued on the same edge.
- R8: With `rdEnN` high, `rdData` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadN | input | 1 | Offset access strobe, active low |
| wrEnN | input | 1 | Write enable, active low |
| rdEnN | input | 1 | Read enable, active low |
| dataIn | input | 18 | Input word; bits 11..0 carry an offset |
| emptyOfs | output | 12 | Current empty-side offset |
| fullOfs | output | 12 | Current full-side offset |
| rdData | output | 18 | Readback word |

## Verification
The assertions watch, on every edge, that a load-write lands in the register the pointer names while the other stays put, that a stalled or released load freezes the write pointer, that readback bits above the offset width stay zero, that the readback word holds without a read strobe, and that load-write and load-read never coincide. Only the bench's scenarios can show the whole round-robin order over many accesses, that an interrupted run resumes at the right register, that the readback pointer walks independently of intervening writes, and that a second reset returns both pointers to the empty-side offset; it does this by comparing all outputs against a behavioural model after every clock.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic wrStb;  // load-write on this write-clock edge
    logic wrSel;  // 0 = empty-side offset, 1 = full-side offset
    logic rdStb;  // load-read on this read-clock edge
    logic rdSel;  // register returned by the load-read
  } ofsStrobe_t;

  function automatic int defaultOffset(input int depth);
    if (depth <= 256)      return 31;
    else if (depth <= 512) return 63;
    else                   return 127;
  endfunction

endpackage

// File: rtl/ofs_seq_ctrl.sv
module ofs_seq_ctrl
  import ofs_seq_pkg::*;
(
  input  logic       wrClk,
  input  logic       rdClk,
  input  logic       rstN,
  input  logic       loadN,
  input  logic       wrEnN,
  input  logic       rdEnN,
  output ofsStrobe_t stb
);

  logic wrPtr;
  logic rdPtr;
  logic loadWr;
  logic loadRd;

  assign loadWr = !loadN && !wrEnN;
  assign loadRd = !loadN && !rdEnN;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN)       wrPtr <= 1'b0;
    else if (loadWr) wrPtr <= ~wrPtr;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)       rdPtr <= 1'b0;
    else if (loadRd) rdPtr <= ~rdPtr;
  end

  always_comb begin
    stb.wrStb = loadWr;
    stb.wrSel = wrPtr;
    stb.rdStb = loadRd;
    stb.rdSel = rdPtr;
  end

  // R4: a stalled load leaves the write pointer where it is
  a_r4_ptr_stall: assert property (@(posedge wrClk) disable iff (!rstN)
    (!loadN && wrEnN) |=> $stable(wrPtr));

  // R5: normal operation freezes both pointers
  a_r5_wr_ptr_idle: assert property (@(posedge wrClk) disable iff (!rstN)
    loadN |=> $stable(wrPtr));
  a_r5_rd_ptr_idle: assert property (@(posedge rdClk) disable iff (!rstN)
    loadN |=> $stable(rdPtr));

  // R2: each load-write moves the pointer to the other register
  a_r2_wr_toggle: assert property (@(posedge wrClk) disable iff (!rstN)
    (!loadN && !wrEnN) |=> (wrPtr != $past(wrPtr)));

  // R7: load-write and load-read never share an edge
  a_r7_exclusive: assert property (@(posedge wrClk) disable iff (!rstN)
    !(!loadN && !wrEnN && !rdEnN));

endmodule

// File: rtl/ofs_seq_data.sv
module ofs_seq_data
  import ofs_seq_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 12,
  parameter logic [OFS_W-1:0] DEF_OFS = 12'h07F
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  ofsStrobe_t        stb,
  input  logic [OFS_W-1:0]  ofsIn,
  output logic [OFS_W-1:0]  emptyOfs,
  output logic [OFS_W-1:0]  fullOfs,
  output logic [DATA_W-1:0] rdData
);

  localparam int NUM_REG = 2;
  localparam int PAD_W   = DATA_W - OFS_W;

  logic [OFS_W-1:0] ofsReg [NUM_REG];

  for (genvar i = 0; i < NUM_REG; i++) begin : g_ofs
    always_ff @(posedge wrClk or negedge rstN) begin
      if (!rstN)
        ofsReg[i] <= DEF_OFS;
      else if (stb.wrStb && (int'(stb.wrSel) == i))
        ofsReg[i] <= ofsIn;
    end
  end

  assign emptyOfs = ofsReg[0];
  assign fullOfs  = ofsReg[1];

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= {{PAD_W{1'b0}}, ofsReg[stb.rdSel]};
  end

  // R2: a load-write lands only in the addressed register
  a_r2_empty_write: assert property (@(posedge wrClk) disable iff (!rstN)
    (stb.wrStb && !stb.wrSel) |=> (emptyOfs == $past(ofsIn)) && $stable(fullOfs));
  a_r2_full_write: assert property (@(posedge wrClk) disable iff (!rstN)
    (stb.wrStb && stb.wrSel) |=> (fullOfs == $past(ofsIn)) && $stable(emptyOfs));

  // R7: readback is zero-extended
  a_r7_upper_zero: assert property (@(posedge rdClk) disable iff (!rstN)
    rdData[DATA_W-1:OFS_W] == '0);

  // R8: readback word holds without a load-read
  a_r8_rd_hold: assert property (@(posedge rdClk) disable iff (!rstN)
    !stb.rdStb |=> $stable(rdData));

endmodule

// File: rtl/ofs_load_seq.sv
module ofs_load_seq
  import ofs_seq_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 12,
  parameter int DEPTH  = 1024
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              loadN,
  input  logic              wrEnN,
  input  logic              rdEnN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [OFS_W-1:0]  emptyOfs,
  output logic [OFS_W-1:0]  fullOfs,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [OFS_W-1:0] DEF_OFS = OFS_W'(defaultOffset(DEPTH));

  ofsStrobe_t stb;
  logic       unusedHiBits;

  // R3: only the low offset bits travel on
  assign unusedHiBits = ^dataIn[DATA_W-1:OFS_W];

  ofs_seq_ctrl u_ctrl (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .rstN  (rstN),
    .loadN (loadN),
    .wrEnN (wrEnN),
    .rdEnN (rdEnN),
    .stb   (stb)
  );

  ofs_seq_data #(
    .DATA_W  (DATA_W),
    .OFS_W   (OFS_W),
    .DEF_OFS (DEF_OFS)
  ) u_data (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .rstN     (rstN),
    .stb      (stb),
    .ofsIn    (dataIn[OFS_W-1:0]),
    .emptyOfs (emptyOfs),
    .fullOfs  (fullOfs),
    .rdData   (rdData)
  );

  // R5: released load keeps both offsets
  a_r5_ofs_idle: assert property (@(posedge wrClk) disable iff (!rstN)
    loadN |=> $stable(emptyOfs) && $stable(fullOfs));

endmodule

// File: tb/ofs_load_seq_tb.sv
module ofs_load_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadN = 1'b1;
  logic        wrEnN = 1'b1;
  logic        rdEnN = 1'b1;
  logic [17:0] dataIn = '0;
  logic [11:0] emptyOfs;
  logic [11:0] fullOfs;
  logic [17:0] rdData;

  int checks = 0;
  int fails = 0;

  // behavioural reference
  int mOfs [2];
  int mWp;
  int mRp;
  int mRd;

  always #5 clk = ~clk;

  ofs_load_seq u_dut (
    .wrClk    (clk),
    .rdClk    (clk),
    .rstN     (rstN),
    .loadN    (loadN),
    .wrEnN    (wrEnN),
    .rdEnN    (rdEnN),
    .dataIn   (dataIn),
    .emptyOfs (emptyOfs),
    .fullOfs  (fullOfs),
    .rdData   (rdData)
  );

  task automatic compare(input string tag);
    checks++;
    if (emptyOfs != 12'(mOfs[0]) || fullOfs != 12'(mOfs[1]) || rdData != 18'(mRd)) begin
      fails++;
      $display("FAIL %s: empty=%h full=%h rd=%h expected empty=%h full=%h rd=%h",
               tag, emptyOfs, fullOfs, rdData, 12'(mOfs[0]), 12'(mOfs[1]), 18'(mRd));
    end
  endtask

  task automatic modelReset();
    mOfs[0] = 127; mOfs[1] = 127; mWp = 0; mRp = 0; mRd = 0;
  endtask

  // one clock: inputs set at the falling edge, outputs checked at the next one
  task automatic cyc(input logic ld, input logic we, input logic re,
                     input logic [17:0] d, input string tag);
    loadN = ld; wrEnN = we; rdEnN = re; dataIn = d;
    if (!ld && !re) begin mRd = mOfs[mRp]; mRp ^= 1; end
    if (!ld && !we) begin mOfs[mWp] = int'(d[11:0]); mWp ^= 1; end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic doReset();
    rstN = 1'b0; loadN = 1'b1; wrEnN = 1'b1; rdEnN = 1'b1;
    modelReset();
    @(negedge clk);
    @(negedge clk);
    compare("R1");
    rstN = 1'b1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    modelReset();
    @(negedge clk);
    doReset();
    cyc(1, 1, 1, 18'h0, "R1");
    // R1: readback of defaults, empty then full
    cyc(0, 1, 0, 18'h0, "R1");
    cyc(0, 1, 0, 18'h0, "R7");
    // R2/R3: empty, full, empty with upper bits set
    cyc(0, 0, 1, 18'h3F123, "R3");
    cyc(0, 0, 1, 18'h00456, "R2");
    cyc(0, 0, 1, 18'h2A789, "R2");
    // R4: stalled load
    cyc(0, 1, 1, 18'h00AAA, "R4");
    cyc(0, 1, 1, 18'h3FBBB, "R4");
    // R5: normal operation ignores enables
    cyc(1, 0, 1, 18'h00CCC, "R5");
    cyc(1, 1, 0, 18'h00DDD, "R5");
    cyc(1, 0, 1, 18'h00EEE, "R5");
    // R6: one write to full, release, resume on empty
    cyc(0, 0, 1, 18'h00111, "R6");
    cyc(1, 1, 1, 18'h0, "R6");
    cyc(1, 0, 1, 18'h00F0F, "R6");
    cyc(0, 0, 1, 18'h00222, "R6");
    cyc(0, 0, 1, 18'h00333, "R6");
    // R7: readback pointer walks independently of writes
    cyc(0, 1, 0, 18'h0, "R7");
    cyc(0, 0, 1, 18'h00444, "R7");
    cyc(0, 1, 0, 18'h0, "R7");
    cyc(0, 1, 0, 18'h0, "R7");
    // R8: holds without read enable
    cyc(0, 1, 1, 18'h0, "R8");
    cyc(1, 1, 1, 18'h0, "R8");
    cyc(0, 0, 1, 18'h00FFF, "R8");
    cyc(1, 1, 1, 18'h0, "R8");
    // loop of alternating writes and reads, all values
    for (int i = 0; i < 40; i++) begin
      cyc(0, 0, 1, 18'((i * 37 + 5) | ((i % 4) << 14)), "R2");
      cyc(0, 1, 0, 18'h0, "R7");
    end
    // R1: reset mid-sequence returns pointers to empty
    cyc(0, 0, 1, 18'h00555, "R2");
    doReset();
    cyc(0, 0, 1, 18'h00666, "R1");
    cyc(0, 1, 0, 18'h0, "R1");
    cyc(0, 1, 0, 18'h0, "R7");
    cyc(1, 1, 1, 18'h0, "R5");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule